// File: doc/BRIEF.md
# Five-Stage In-Order Integer Pipeline

This block is a 32-bit in-order integer core that splits every instruction into five steps: fetch, decode with register read, execute, memory access and register writeback. A pipeline register sits between each pair of neighbouring steps. In steady state one instruction enters per cycle. Instruction and data storage sit outside the block. Both are small word arrays with a combinational read and a write on the rising clock edge. The core drives a fetch address and a data address, and it receives the read word back in the same cycle.

The instruction set is small. It has register-register ALU operations, ALU operations with a sign-extended 16-bit immediate, word load, word store and a branch taken when a register is zero. The branch decision and target are registered at the end of execute. Fetch acts on them one cycle later, and the three younger instructions already in flight are discarded. The core has no operand forwarding and no interlock of its own. A separate hazard unit may raise `stall_i` to freeze fetch and decode while a bubble goes down the pipe. Every register write is shown on a trace port.

Reset is asynchronous and active low. Its release must be synchronous to `clk`.

Top module: `pipe5_core`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after its release, `imem_addr_o` is 0 and `trace_we_o`, `dmem_we_o` and `dmem_re_o` are all 0.
- R2: Instruction fields are: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], bits [10:6] zero, function [5:0]. Opcode 0 with function 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x26 xor or 0x2A signed set-less-than writes rs op rt to rd. This write shows on the trace port 4 cycles after the instruction's address is on `imem_addr_o`, when no stall or taken branch intervenes.
- R3: Opcodes 0x08 add, 0x0C and, 0x0D or, 0x0E xor and 0x0A signed set-less-than combine rs with the sign-extended immediate in [15:0] and write the result to rt.
- R4: Opcode 0x23 loads the data word at byte address rs + sign-extended immediate into rt, and asserts `dmem_re_o` during the access.
- R5: Opcode 0x2B writes rt to byte address rs + sign-extended immediate through `dmem_we_o` for one cycle. `dmem_we_o` and `dmem_re_o` are never high together.
- R6: Register 0 always reads as zero. An instruction whose destination is register 0 produces no trace write.
- R7: A decode in the same cycle as a writeback to the same register sees the new value, so an instruction three slots after its producer reads the new result.
- R8: There is no forwarding. Instructions one or two slots after a producer read the register's previous value.
- R9: With no stall and no taken branch, `imem_addr_o` grows by 4 every cycle.
- R10: Opcode 0x04 is a branch taken when rs equals zero. Its target is the branch address + 4 + (sign-extended immediate shifted left by 2). The target appears on `imem_addr_o` 4 cycles after the branch was fetched, and the three instructions fetched after the branch write nothing.
- R11: A branch whose rs is nonzero leaves the fetch sequence and all results unchanged.
- R12: While `stall_i` is high, the fetch address and the instruction in decode hold, and a bubble enters execute. Each stall cycle delays every instruction that has not yet left decode by one cycle. No instruction is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall_i | input | 1 | Hold fetch and decode, insert a bubble into execute |
| imem_addr_o | output | 32 | Fetch byte address (the PC) |
| imem_rdata_i | input | 32 | Instruction word at `imem_addr_o` |
| dmem_addr_o | output | 32 | Data byte address of the access in the memory stage |
| dmem_re_o | output | 1 | Load in the memory stage |
| dmem_we_o | output | 1 | Store in the memory stage, written on the next rising edge |
| dmem_wdata_o | output | 32 | Store data |
| dmem_rdata_i | input | 32 | Data word at `dmem_addr_o` |
| trace_we_o | output | 1 | A register is written this cycle |
| trace_reg_o | output | 5 | Index of the register written |
| trace_data_o | output | 32 | Value written |

## Verification
When nothing intervenes, a result reaches the trace port 4 cycles after its instruction's address was on the fetch port. Each stall cycle adds one cycle to every instruction that has not left decode. A taken branch puts its target on the fetch port 4 cycles after the branch itself was fetched. The bench reads the outputs at the falling edge and tags each sample with the number of rising edges since reset release. Trace writes and fetch addresses are stored with that index and compared with arithmetic predictions of the cycle and the value. For the stall sweeps, the bench works out the expected decode-leaving cycle of each instruction from the stall pattern, and expects the trace write 3 cycles after it.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;

  localparam int unsigned FIELD_W = 5;

  localparam logic [5:0] OPC_REG    = 6'h00;
  localparam logic [5:0] OPC_BRZ    = 6'h04;
  localparam logic [5:0] OPC_ADDI   = 6'h08;
  localparam logic [5:0] OPC_SLTI   = 6'h0A;
  localparam logic [5:0] OPC_ANDI   = 6'h0C;
  localparam logic [5:0] OPC_ORI    = 6'h0D;
  localparam logic [5:0] OPC_XORI   = 6'h0E;
  localparam logic [5:0] OPC_LOADW  = 6'h23;
  localparam logic [5:0] OPC_STOREW = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_XOR = 6'h26;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_SLT
  } alu_op_e;

  typedef struct packed {
    logic               wr_en;
    logic               use_imm;
    logic               is_load;
    logic               is_store;
    logic               is_branch;
    alu_op_e            op;
    logic [FIELD_W-1:0] dest;
  } ctrl_t;

  localparam ctrl_t CTRL_NOP = '{
    wr_en: 1'b0, use_imm: 1'b0, is_load: 1'b0, is_store: 1'b0,
    is_branch: 1'b0, op: ALU_ADD, dest: '0
  };

endpackage

// File: rtl/pipe5_decode.sv
module pipe5_decode
  import pipe5_pkg::*;
(
  input  logic [5:0]         opcode_i,
  input  logic [FIELD_W-1:0] rt_i,
  input  logic [FIELD_W-1:0] rd_i,
  input  logic [FIELD_W-1:0] shamt_i,
  input  logic [5:0]         funct_i,
  output ctrl_t              ctrl_o
);

  logic  known;
  logic  writes;
  ctrl_t raw;

  always_comb begin
    raw    = CTRL_NOP;
    known  = 1'b1;
    writes = 1'b1;
    raw.dest = rt_i;
    case (opcode_i)
      OPC_REG: begin
        raw.dest = rd_i;
        case (funct_i)
          FN_ADD:  raw.op = ALU_ADD;
          FN_SUB:  raw.op = ALU_SUB;
          FN_AND:  raw.op = ALU_AND;
          FN_OR:   raw.op = ALU_OR;
          FN_XOR:  raw.op = ALU_XOR;
          FN_SLT:  raw.op = ALU_SLT;
          default: known  = 1'b0;
        endcase
        if (shamt_i != '0) known = 1'b0;
      end
      OPC_ADDI:  begin raw.op = ALU_ADD; raw.use_imm = 1'b1; end
      OPC_SLTI:  begin raw.op = ALU_SLT; raw.use_imm = 1'b1; end
      OPC_ANDI:  begin raw.op = ALU_AND; raw.use_imm = 1'b1; end
      OPC_ORI:   begin raw.op = ALU_OR;  raw.use_imm = 1'b1; end
      OPC_XORI:  begin raw.op = ALU_XOR; raw.use_imm = 1'b1; end
      OPC_LOADW: begin
        raw.op = ALU_ADD; raw.use_imm = 1'b1; raw.is_load = 1'b1;
      end
      OPC_STOREW: begin
        raw.op = ALU_ADD; raw.use_imm = 1'b1; raw.is_store = 1'b1;
        writes = 1'b0;
      end
      OPC_BRZ: begin
        raw.is_branch = 1'b1;
        writes = 1'b0;
      end
      default: known = 1'b0;
    endcase
    raw.wr_en = writes && (raw.dest != '0);
    ctrl_o = known ? raw : CTRL_NOP;
  end

endmodule

// File: rtl/pipe5_alu.sv
module pipe5_alu
  import pipe5_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] y_o
);

  logic lt;

  always_comb begin
    lt = $signed(a_i) < $signed(b_i);
    case (op_i)
      ALU_ADD: y_o = a_i + b_i;
      ALU_SUB: y_o = a_i - b_i;
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_XOR: y_o = a_i ^ b_i;
      ALU_SLT: y_o = {{(DATA_W-1){1'b0}}, lt};
      default: y_o = '0;
    endcase
  end

endmodule

// File: rtl/pipe5_regfile.sv
module pipe5_regfile #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned REG_N  = 32,
  parameter int unsigned RD_N   = 2,
  localparam int unsigned AW    = $clog2(REG_N)
) (
  input  logic                       clk,
  input  logic                       we_i,
  input  logic [AW-1:0]              waddr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  input  logic [RD_N-1:0][AW-1:0]    raddr_i,
  output logic [RD_N-1:0][DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] regs [REG_N];
  logic              wr_ok;

  assign wr_ok = we_i && (waddr_i != '0);

  always_ff @(posedge clk) begin
    if (wr_ok) regs[waddr_i] <= wdata_i;
  end

  for (genvar p = 0; p < RD_N; p++) begin : g_rd
    always_comb begin
      if (raddr_i[p] == '0)
        rdata_o[p] = '0;
      else if (wr_ok && (waddr_i == raddr_i[p]))
        rdata_o[p] = wdata_i;
      else
        rdata_o[p] = regs[raddr_i[p]];
    end
  end

endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
  import pipe5_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned REG_N    = 32,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall_i,
  output logic [DATA_W-1:0] imem_addr_o,
  input  logic [31:0]       imem_rdata_i,
  output logic [DATA_W-1:0] dmem_addr_o,
  output logic              dmem_re_o,
  output logic              dmem_we_o,
  output logic [DATA_W-1:0] dmem_wdata_o,
  input  logic [DATA_W-1:0] dmem_rdata_i,
  output logic              trace_we_o,
  output logic [4:0]        trace_reg_o,
  output logic [DATA_W-1:0] trace_data_o
);

  localparam int unsigned RF_AW   = $clog2(REG_N);
  localparam logic [DATA_W-1:0] PC_STEP = DATA_W'(4);
  localparam logic [DATA_W-1:0] PC_INIT = DATA_W'(RESET_PC);

  // fetch and fetch/decode register
  logic [DATA_W-1:0] pc_q, pc_d;
  logic              pc_en, ifid_en;
  logic              ifid_valid_q, ifid_valid_d;
  logic [31:0]       ifid_ir_q;
  logic [DATA_W-1:0] ifid_npc_q, ifid_npc_d;

  // decode/execute register
  logic              idex_valid_q, idex_valid_d;
  ctrl_t             idex_ctrl_q, dec_ctrl;
  logic [DATA_W-1:0] idex_a_q, idex_b_q, idex_imm_q, idex_npc_q;
  logic [DATA_W-1:0] dec_imm;
  logic [1:0][RF_AW-1:0]  rf_raddr;
  logic [1:0][DATA_W-1:0] rf_rdata;

  // execute/memory register
  logic              exmem_valid_q, exmem_valid_d;
  logic              exmem_wr_q, exmem_load_q, exmem_store_q, exmem_branch_q;
  logic [4:0]        exmem_dest_q;
  logic [DATA_W-1:0] exmem_alu_q, exmem_alu_d, exmem_b_q;
  logic              exmem_cond_q, exmem_cond_d;
  logic [DATA_W-1:0] alu_b, alu_y;

  // memory/writeback register
  logic              memwb_valid_q, memwb_wr_q, memwb_load_q;
  logic [4:0]        memwb_dest_q;
  logic [DATA_W-1:0] memwb_alu_q, memwb_lmd_q;

  logic taken;

  // ---------------- submodules ----------------
  pipe5_decode u_dec (
    .opcode_i (ifid_ir_q[31:26]),
    .rt_i     (ifid_ir_q[20:16]),
    .rd_i     (ifid_ir_q[15:11]),
    .shamt_i  (ifid_ir_q[10:6]),
    .funct_i  (ifid_ir_q[5:0]),
    .ctrl_o   (dec_ctrl)
  );

  assign rf_raddr[0] = ifid_ir_q[21 +: RF_AW];
  assign rf_raddr[1] = ifid_ir_q[16 +: RF_AW];

  pipe5_regfile #(.DATA_W(DATA_W), .REG_N(REG_N), .RD_N(2)) u_rf (
    .clk     (clk),
    .we_i    (trace_we_o),
    .waddr_i (memwb_dest_q[RF_AW-1:0]),
    .wdata_i (trace_data_o),
    .raddr_i (rf_raddr),
    .rdata_o (rf_rdata)
  );

  pipe5_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i (idex_ctrl_q.op),
    .a_i  (idex_a_q),
    .b_i  (alu_b),
    .y_o  (alu_y)
  );

  // ---------------- next-state logic ----------------
  always_comb begin
    taken   = exmem_valid_q && exmem_branch_q && exmem_cond_q;
    pc_en   = taken || !stall_i;
    ifid_en = pc_en;
    pc_d    = taken ? exmem_alu_q : pc_q + PC_STEP;
    ifid_valid_d = !taken;
    ifid_npc_d   = pc_q + PC_STEP;

    dec_imm      = {{(DATA_W-16){ifid_ir_q[15]}}, ifid_ir_q[15:0]};
    idex_valid_d = ifid_valid_q && !taken && !stall_i;

    alu_b         = idex_ctrl_q.use_imm ? idex_imm_q : idex_b_q;
    exmem_valid_d = idex_valid_q && !taken;
    exmem_cond_d  = (idex_a_q == '0);
    exmem_alu_d   = idex_ctrl_q.is_branch ? idex_npc_q + (idex_imm_q << 2) : alu_y;
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q          <= PC_INIT;
      ifid_valid_q  <= 1'b0;
      ifid_ir_q     <= '0;
      ifid_npc_q    <= '0;
      idex_valid_q  <= 1'b0;
      idex_ctrl_q   <= CTRL_NOP;
      idex_a_q      <= '0;
      idex_b_q      <= '0;
      idex_imm_q    <= '0;
      idex_npc_q    <= '0;
      exmem_valid_q <= 1'b0;
      exmem_wr_q    <= 1'b0;
      exmem_load_q  <= 1'b0;
      exmem_store_q <= 1'b0;
      exmem_branch_q <= 1'b0;
      exmem_dest_q  <= '0;
      exmem_alu_q   <= '0;
      exmem_b_q     <= '0;
      exmem_cond_q  <= 1'b0;
      memwb_valid_q <= 1'b0;
      memwb_wr_q    <= 1'b0;
      memwb_load_q  <= 1'b0;
      memwb_dest_q  <= '0;
      memwb_alu_q   <= '0;
      memwb_lmd_q   <= '0;
    end else begin
      if (pc_en) pc_q <= pc_d;
      if (ifid_en) begin
        ifid_valid_q <= ifid_valid_d;
        ifid_ir_q    <= imem_rdata_i;
        ifid_npc_q   <= ifid_npc_d;
      end
      idex_valid_q <= idex_valid_d;
      idex_ctrl_q  <= dec_ctrl;
      idex_a_q     <= rf_rdata[0];
      idex_b_q     <= rf_rdata[1];
      idex_imm_q   <= dec_imm;
      idex_npc_q   <= ifid_npc_q;
      exmem_valid_q  <= exmem_valid_d;
      exmem_wr_q     <= idex_ctrl_q.wr_en;
      exmem_load_q   <= idex_ctrl_q.is_load;
      exmem_store_q  <= idex_ctrl_q.is_store;
      exmem_branch_q <= idex_ctrl_q.is_branch;
      exmem_dest_q   <= idex_ctrl_q.dest;
      exmem_alu_q    <= exmem_alu_d;
      exmem_b_q      <= idex_b_q;
      exmem_cond_q   <= exmem_cond_d;
      memwb_valid_q <= exmem_valid_q;
      memwb_wr_q    <= exmem_wr_q;
      memwb_load_q  <= exmem_load_q;
      memwb_dest_q  <= exmem_dest_q;
      memwb_alu_q   <= exmem_alu_q;
      memwb_lmd_q   <= dmem_rdata_i;
    end
  end

  // ---------------- outputs ----------------
  assign imem_addr_o  = pc_q;
  assign dmem_addr_o  = exmem_alu_q;
  assign dmem_wdata_o = exmem_b_q;
  assign dmem_we_o    = exmem_valid_q && exmem_store_q;
  assign dmem_re_o    = exmem_valid_q && exmem_load_q;
  assign trace_we_o   = memwb_valid_q && memwb_wr_q;
  assign trace_reg_o  = memwb_dest_q;
  assign trace_data_o = memwb_load_q ? memwb_lmd_q : memwb_alu_q;

  // ---------------- assertions ----------------
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (imem_addr_o == PC_INIT) && !trace_we_o && !dmem_we_o && !dmem_re_o); // R1

  AST_MEM_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(dmem_we_o && dmem_re_o)); // R5

  AST_NO_R0_TRACE: assert property (@(posedge clk) disable iff (!rst_n)
    trace_we_o |-> (trace_reg_o != '0)); // R6

  AST_SEQ_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_i && !taken) |=> (imem_addr_o == $past(imem_addr_o) + PC_STEP)); // R9

  AST_BRANCH_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    taken |=> (imem_addr_o == $past(dmem_addr_o))); // R10

  AST_BRANCH_SQUASH: assert property (@(posedge clk) disable iff (!rst_n)
    taken |=> !ifid_valid_q && !idex_valid_q && !exmem_valid_q); // R10

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_i && !taken) |=> $stable(imem_addr_o) && $stable(ifid_ir_q) && !idex_valid_q); // R12

endmodule

// File: tb/pipe5_core_test.sv
module pipe5_core_test;
  import pipe5_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        stall_i;
  logic [31:0] imem_addr_o, imem_rdata_i;
  logic [31:0] dmem_addr_o, dmem_wdata_o, dmem_rdata_i;
  logic        dmem_re_o, dmem_we_o;
  logic        trace_we_o;
  logic [4:0]  trace_reg_o;
  logic [31:0] trace_data_o;

  always #4 clk = ~clk;

  pipe5_core uut (
    .clk(clk), .rst_n(rst_n), .stall_i(stall_i),
    .imem_addr_o(imem_addr_o), .imem_rdata_i(imem_rdata_i),
    .dmem_addr_o(dmem_addr_o), .dmem_re_o(dmem_re_o), .dmem_we_o(dmem_we_o),
    .dmem_wdata_o(dmem_wdata_o), .dmem_rdata_i(dmem_rdata_i),
    .trace_we_o(trace_we_o), .trace_reg_o(trace_reg_o), .trace_data_o(trace_data_o)
  );

  logic [31:0] imem [0:255];
  logic [31:0] dmem [0:255];
  assign imem_rdata_i = imem[imem_addr_o[9:2]];
  assign dmem_rdata_i = dmem[dmem_addr_o[9:2]];
  always @(posedge clk) if (dmem_we_o) dmem[dmem_addr_o[9:2]] <= dmem_wdata_o;

  int checks = 0;
  int errors = 0;

  int          log_n;
  int          log_reg [64];
  logic [31:0] log_val [64];
  int          log_cyc [64];
  logic [31:0] pc_log  [64];
  logic        stall_pat [64];

  int          exp_n;
  int          exp_reg [64];
  logic [31:0] exp_val [64];
  int          exp_cyc [64];

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(input int rd, input int rs, input int rt, input logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rt, input int rs, input int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  function automatic logic [31:0] sx(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  task automatic clear_all();
    for (int i = 0; i < 256; i++) begin imem[i] = 32'h0; dmem[i] = 32'h0; end
    for (int i = 0; i < 64; i++) stall_pat[i] = 1'b0;
    exp_n = 0;
  endtask

  task automatic expect_w(input int r, input logic [31:0] v, input int c);
    exp_reg[exp_n] = r; exp_val[exp_n] = v; exp_cyc[exp_n] = c; exp_n++;
  endtask

  task automatic run(input int ncyc);
    stall_i = 1'b0;
    log_n   = 0;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "pc in reset", imem_addr_o, 32'h0);
    chk("R1", "quiet in reset", {29'd0, trace_we_o, dmem_we_o, dmem_re_o}, 32'h0);
    rst_n = 1'b1;
    pc_log[0] = imem_addr_o;
    stall_i = stall_pat[0];
    for (int k = 1; k <= ncyc; k++) begin
      @(negedge clk);
      if (k == 1)
        chk("R1", "quiet after release", {29'd0, trace_we_o, dmem_we_o, dmem_re_o}, 32'h0);
      pc_log[k] = imem_addr_o;
      if (trace_we_o && log_n < 64) begin
        log_reg[log_n] = int'(trace_reg_o);
        log_val[log_n] = trace_data_o;
        log_cyc[log_n] = k;
        log_n++;
      end
      stall_i = stall_pat[k];
    end
    stall_i = 1'b0;
  endtask

  task automatic compare(input string req);
    chk(req, "write count", 32'(log_n), 32'(exp_n));
    for (int i = 0; i < exp_n && i < log_n; i++) begin
      chk(req, "dest", 32'(log_reg[i]), 32'(exp_reg[i]));
      chk(req, "data", log_val[i], exp_val[i]);
      if (exp_cyc[i] >= 0) chk(req, "cycle", 32'(log_cyc[i]), 32'(exp_cyc[i]));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] a, b, ix;
    rst_n   = 1'b0;
    stall_i = 1'b0;

    // R2 R3 R4 R5 R6 R7: operand sweep through every ALU function
    for (int j = 0; j < 8; j++) begin
      clear_all();
      a  = (32'h1234_5678 * 32'(j + 1)) ^ (32'(j) << 28);
      b  = 32'hFEDC_BA98 - 32'(j) * 32'h0101_0101;
      ix = sx(16'(j * 4951 + 32769 * (j % 2)));
      dmem[0] = a; dmem[1] = b;
      imem[0]  = enc_i(OPC_LOADW, 1, 0, 0);
      imem[1]  = enc_i(OPC_LOADW, 2, 0, 4);
      imem[2]  = enc_i(OPC_ADDI, 16, 0, 32'h40);
      imem[4]  = enc_r(3, 1, 2, FN_ADD);
      imem[5]  = enc_r(4, 1, 2, FN_SUB);
      imem[6]  = enc_r(5, 1, 2, FN_AND);
      imem[7]  = enc_r(6, 1, 2, FN_OR);
      imem[8]  = enc_r(7, 1, 2, FN_XOR);
      imem[9]  = enc_r(8, 1, 2, FN_SLT);
      imem[10] = enc_i(OPC_ADDI, 9, 1, int'(ix[15:0]));
      imem[11] = enc_i(OPC_ANDI, 10, 1, int'(ix[15:0]));
      imem[12] = enc_i(OPC_ORI, 11, 1, int'(ix[15:0]));
      imem[13] = enc_i(OPC_XORI, 12, 1, int'(ix[15:0]));
      imem[14] = enc_i(OPC_SLTI, 13, 1, int'(ix[15:0]));
      imem[15] = enc_i(OPC_STOREW, 3, 0, 8);
      imem[16] = enc_i(OPC_LOADW, 14, 0, 8);
      imem[17] = enc_r(0, 1, 2, FN_ADD);
      imem[18] = enc_r(15, 0, 1, FN_ADD);
      imem[19] = enc_i(OPC_STOREW, 2, 16, -8);
      imem[20] = enc_i(OPC_LOADW, 17, 16, -8);
      expect_w(1, a, 4);
      expect_w(2, b, 5);
      expect_w(16, 32'h40, 6);
      expect_w(3, a + b, 8);
      expect_w(4, a - b, 9);
      expect_w(5, a & b, 10);
      expect_w(6, a | b, 11);
      expect_w(7, a ^ b, 12);
      expect_w(8, ($signed(a) < $signed(b)) ? 32'd1 : 32'd0, 13);
      expect_w(9, a + ix, 14);
      expect_w(10, a & ix, 15);
      expect_w(11, a | ix, 16);
      expect_w(12, a ^ ix, 17);
      expect_w(13, ($signed(a) < $signed(ix)) ? 32'd1 : 32'd0, 18);
      expect_w(14, a + b, 20);
      expect_w(15, a, 22);
      expect_w(17, b, 24);
      run(30);
      compare("R2/R3/R4/R6/R7");
      chk("R5", "store at 8", dmem[2], a + b);
      chk("R5", "store at base-8", dmem[14], b);
      for (int k = 0; k < 12; k++) chk("R9", "sequential pc", pc_log[k], 32'(4 * k));
    end

    // R8 R7: no forwarding, same-cycle write then read
    clear_all();
    imem[0] = enc_i(OPC_ADDI, 1, 0, 1);
    imem[4] = enc_i(OPC_ADDI, 1, 0, 2);
    imem[5] = enc_i(OPC_ADDI, 2, 1, 0);
    imem[6] = enc_i(OPC_ADDI, 3, 1, 0);
    imem[7] = enc_i(OPC_ADDI, 4, 1, 0);
    expect_w(1, 1, 4);
    expect_w(1, 2, 8);
    expect_w(2, 1, 9);
    expect_w(3, 1, 10);
    expect_w(4, 2, 11);
    run(16);
    compare("R8/R7");

    // R10 R11: taken forward, not taken, taken backward, squash of younger slots
    clear_all();
    imem[0]  = enc_i(OPC_ADDI, 1, 0, 5);
    imem[1]  = enc_i(OPC_BRZ, 0, 0, 4);
    imem[2]  = enc_i(OPC_ADDI, 2, 0, 1);
    imem[3]  = enc_i(OPC_ADDI, 3, 0, 2);
    imem[4]  = enc_i(OPC_ADDI, 4, 0, 3);
    imem[5]  = enc_i(OPC_ADDI, 5, 0, 4);
    imem[6]  = enc_i(OPC_ADDI, 6, 0, 7);
    imem[7]  = enc_i(OPC_BRZ, 0, 1, 2);
    imem[8]  = enc_i(OPC_ADDI, 7, 0, 8);
    imem[9]  = enc_i(OPC_ADDI, 8, 0, -3);
    imem[10] = enc_i(OPC_BRZ, 0, 0, 5);
    imem[11] = enc_i(OPC_ADDI, 12, 0, 1);
    imem[12] = enc_i(OPC_ADDI, 10, 0, 10);
    imem[13] = enc_i(OPC_BRZ, 0, 0, 10);
    imem[14] = enc_i(OPC_ADDI, 13, 0, 1);
    imem[15] = enc_i(OPC_ADDI, 14, 0, 1);
    imem[16] = enc_i(OPC_ADDI, 9, 0, 9);
    imem[17] = enc_i(OPC_BRZ, 0, 0, -6);
    imem[18] = enc_i(OPC_ADDI, 18, 0, 1);
    imem[19] = enc_i(OPC_ADDI, 19, 0, 1);
    imem[20] = enc_i(OPC_ADDI, 20, 0, 1);
    imem[24] = enc_i(OPC_ADDI, 11, 0, 11);
    expect_w(1, 5, 4);
    expect_w(6, 7, 9);
    expect_w(7, 8, -1);
    expect_w(8, 32'hFFFF_FFFD, -1);
    expect_w(9, 9, -1);
    expect_w(10, 10, -1);
    expect_w(11, 11, 27);
    run(35);
    compare("R10/R11");
    chk("R10", "pc before redirect", pc_log[4], 32'd16);
    chk("R10", "forward target", pc_log[5], 32'd24);
    chk("R11", "not taken continues", pc_log[10], 32'd44);
    chk("R10", "second forward target", pc_log[13], 32'd64);
    chk("R10", "backward target", pc_log[18], 32'd48);
    chk("R10", "third target", pc_log[23], 32'd96);

    // R12: stall pattern sweep
    for (int p = 0; p < 4; p++) begin
      clear_all();
      for (int k = 0; k < 16; k++) stall_pat[k] = ((k * (p + 2) + p) % 5) == 0;
      for (int i = 0; i < 8; i++) begin
        int lv;
        imem[i] = enc_i(OPC_ADDI, i + 1, 0, 100 * (p + 1) + i);
        lv = i + 1;
        for (int s = 0; s < 64; s++) if (stall_pat[s] && s <= lv) lv++;
        expect_w(i + 1, 32'(100 * (p + 1) + i), lv + 3);
      end
      run(40);
      compare("R12");
      for (int k = 0; k < 15; k++)
        if (stall_pat[k]) chk("R12", "pc held", pc_log[k + 1], pc_log[k]);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule